// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hertz, the rate of a chosen internal clock from the settings that control a clock tree. The tree starts at a fixed 24 MHz crystal. A system PLL multiplies it by 20 or by 22, and two fractional taps scale the PLL by 18 divided by their own fraction fields. Source muxes pick among the PLL, the taps, a USB PLL at 20 times the crystal, the crystal itself and a bypass input counted as 0 Hz. Four post-divider stages then divide the result, each by one plus its own field. No real clock is produced here. The block only does the arithmetic, so that timer or baud-rate logic elsewhere can learn the rate it is being fed.

A client raises `req_valid` with a request code while `busy` is low. All control fields are captured on the same edge. Constant requests are answered on the accepting edge. The two derived clocks are answered after a fixed run of sequential divisions. Every answer is a single-cycle `rsp_valid` pulse, and `rsp_hz` holds the value until the next answer. Each division truncates toward zero, and a zero fraction field gives 0 Hz rather than a fault.

Top module: `clkfreq_calc`

## Requirements
- R1: After reset `busy` is 0, `rsp_valid` is 0 and `rsp_hz` is 0.
- R2: Request code 3 returns 24,000,000. Code 4 returns 3,000,000. Codes 0, 5, 6 and 7 return 0. All of these are answered at the accepting edge.
- R3: The system PLL is 528,000,000 Hz when `sys_pll_x22` is 1 and 480,000,000 Hz when it is 0. A tap equals PLL*18/fraction. `pre_sel` chooses 0: PLL, 1: tap on `pfd2_frac`, 2: tap on `pfd0_frac`, 3: the `pfd2_frac` tap halved.
- R4: A tap whose fraction field is 0 counts as 0 Hz.
- R5: The alternate source chooses by `alt_sel`: 0: 480,000,000, 1: 24,000,000, 2 and 3: 0. It is then divided by 1+`alt_div`.
- R6: The peripheral root is the `pre_sel` result when `periph_sel` is 0 and the divided alternate source when it is 1. AHB is root/(1+`ahb_div`). IPG is AHB/(1+`ipg_div`). Request code 1 returns IPG.
- R7: Request code 2 returns (`per_sel` ? 24,000,000 : IPG)/(1+`per_div`).
- R8: Every stage truncates its own quotient before the next stage uses it.
- R9: Counting the accepting edge as edge 1, `rsp_valid` is seen after edge 1 for codes 0 and 3 to 7. It is seen after edge 4*(FREQ_W+2)+1 for code 1 and after edge 5*(FREQ_W+2)+1 for code 2.
- R10: `busy` is high from the accepting edge of a code 1 or 2 request until its answer. `rsp_valid` lasts exactly one cycle. `rsp_hz` keeps its value afterwards.
- R11: A request raised while `busy` is high is ignored: it produces no answer of its own.
- R12: Control fields are sampled only at acceptance. Changing them while `busy` is high does not alter the answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_id | input | 3 | Request code (see R2, R6, R7) |
| sys_pll_x22 | input | 1 | System PLL multiplier select (1: x22, 0: x20) |
| pfd0_frac | input | FRAC_W | Fraction field of tap 0 |
| pfd2_frac | input | FRAC_W | Fraction field of tap 2 |
| pre_sel | input | 2 | Pre-peripheral source select |
| alt_sel | input | 2 | Alternate source select |
| alt_div | input | ALT_DIV_W | Alternate post-divider field |
| periph_sel | input | 1 | Peripheral root select |
| ahb_div | input | AHB_DIV_W | AHB post-divider field |
| ipg_div | input | IPG_DIV_W | IPG post-divider field |
| per_sel | input | 1 | Per-clock source select |
| per_div | input | PER_DIV_W | Per-clock post-divider field |
| busy | output | 1 | A derived request is in progress |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_hz | output | FREQ_W | Answer in hertz |

## Verification
A constant answer is due one edge after acceptance. An IPG answer takes four divisions of FREQ_W+2 cycles each, and a per-clock answer takes five. The bench drives each request on a falling edge and counts falling edges from acceptance until `rsp_valid` is seen. It compares that count with the exact figure from R9, then reads `rsp_hz` in the same half cycle. In the following cycle it confirms that the strobe has dropped while the value holds. For R11 and R12, fields are scrambled and stray requests are raised a few cycles into a run, and the bench then watches for any extra answer.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;

  localparam longint unsigned OSC_HZ      = 64'd24_000_000;
  localparam longint unsigned SYS_LO_MUL  = 64'd20;
  localparam longint unsigned SYS_HI_MUL  = 64'd22;
  localparam longint unsigned USB_MUL     = 64'd20;
  localparam longint unsigned TAP_MUL     = 64'd18;
  localparam longint unsigned OSC_DIV_CONST = 64'd8;

  localparam int unsigned REQ_W = 3;

  typedef enum logic [REQ_W-1:0] {
    REQ_NONE     = 3'd0,
    REQ_IPG      = 3'd1,
    REQ_PER      = 3'd2,
    REQ_OSC      = 3'd3,
    REQ_OSC_DIV8 = 3'd4
  } req_e;

  typedef enum logic [2:0] {
    STG_TAP = 3'd0,
    STG_ALT = 3'd1,
    STG_AHB = 3'd2,
    STG_IPG = 3'd3,
    STG_PER = 3'd4
  } stage_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

endpackage

// File: rtl/clkfreq_divider.sv
// Restoring divider: one quotient bit per cycle, W iterations per division.
// A zero divisor yields a zero quotient (R4).
module clkfreq_divider #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int unsigned CNT_W = $clog2(W + 1);

  logic             active_q, active_d;
  logic             done_q, done_d;
  logic             zero_q, zero_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dvs_q, dvs_d;

  logic [W:0]       shifted;
  logic [W:0]       trial;
  logic             fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = ~trial[W];
  end

  always_comb begin
    active_d = active_q;
    done_d   = 1'b0;
    zero_d   = zero_q;
    cnt_d    = cnt_q;
    rem_d    = rem_q;
    quo_d    = quo_q;
    dvs_d    = dvs_q;
    if (start && !active_q) begin
      active_d = 1'b1;
      cnt_d    = CNT_W'(W);
      rem_d    = '0;
      quo_d    = dividend;
      dvs_d    = divisor;
      zero_d   = (divisor == '0);
    end else if (active_q) begin
      rem_d = fits ? trial[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      zero_q   <= 1'b0;
      cnt_q    <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      dvs_q    <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      zero_q   <= zero_d;
      cnt_q    <= cnt_d;
      rem_q    <= rem_d;
      quo_q    <= quo_d;
      dvs_q    <= dvs_d;
    end
  end

  assign done     = done_q;
  assign quotient = zero_q ? '0 : quo_q;

endmodule

// File: rtl/clkfreq_operands.sv
// Chooses the dividend and divisor of each stage from captured fields and
// earlier stage results (R3, R5, R6, R7).
module clkfreq_operands
  import clkfreq_pkg::*;
#(
  parameter int unsigned FREQ_W    = 64,
  parameter int unsigned FRAC_W    = 6,
  parameter int unsigned ALT_DIV_W = 3,
  parameter int unsigned AHB_DIV_W = 3,
  parameter int unsigned IPG_DIV_W = 2,
  parameter int unsigned PER_DIV_W = 6
) (
  input  stage_e                stage,
  input  logic                  sys_pll_x22,
  input  logic [FRAC_W-1:0]     pfd0_frac,
  input  logic [FRAC_W-1:0]     pfd2_frac,
  input  logic [1:0]            pre_sel,
  input  logic [1:0]            alt_sel,
  input  logic [ALT_DIV_W-1:0]  alt_div,
  input  logic                  periph_sel,
  input  logic [AHB_DIV_W-1:0]  ahb_div,
  input  logic [IPG_DIV_W-1:0]  ipg_div,
  input  logic                  per_sel,
  input  logic [PER_DIV_W-1:0]  per_div,
  input  logic [FREQ_W-1:0]     tap_hz,
  input  logic [FREQ_W-1:0]     alt_hz,
  input  logic [FREQ_W-1:0]     ahb_hz,
  input  logic [FREQ_W-1:0]     ipg_hz,
  output logic [FREQ_W-1:0]     dividend,
  output logic [FREQ_W-1:0]     divisor
);

  localparam logic [FREQ_W-1:0] OSC      = FREQ_W'(OSC_HZ);
  localparam logic [FREQ_W-1:0] SYS_LO   = FREQ_W'(OSC_HZ * SYS_LO_MUL);
  localparam logic [FREQ_W-1:0] SYS_HI   = FREQ_W'(OSC_HZ * SYS_HI_MUL);
  localparam logic [FREQ_W-1:0] SYS_LO18 = FREQ_W'(OSC_HZ * SYS_LO_MUL * TAP_MUL);
  localparam logic [FREQ_W-1:0] SYS_HI18 = FREQ_W'(OSC_HZ * SYS_HI_MUL * TAP_MUL);
  localparam logic [FREQ_W-1:0] USB      = FREQ_W'(OSC_HZ * USB_MUL);
  localparam logic [FREQ_W-1:0] ONE      = FREQ_W'(1);

  logic [FREQ_W-1:0] sys_hz;
  logic [FREQ_W-1:0] tap_scaled;
  logic [FRAC_W-1:0] frac_pick;
  logic [FREQ_W-1:0] pre_hz;
  logic [FREQ_W-1:0] alt_src;
  logic [FREQ_W-1:0] root_hz;
  logic [FREQ_W-1:0] per_src;

  always_comb begin
    sys_hz     = sys_pll_x22 ? SYS_HI : SYS_LO;
    tap_scaled = sys_pll_x22 ? SYS_HI18 : SYS_LO18;
    // the tap run in the first stage is the one the pre-mux will use
    frac_pick  = (pre_sel == 2'd2) ? pfd0_frac : pfd2_frac;

    unique case (pre_sel)
      2'd0:    pre_hz = sys_hz;
      2'd3:    pre_hz = tap_hz >> 1;
      default: pre_hz = tap_hz;
    endcase

    unique case (alt_sel)
      2'd0:    alt_src = USB;
      2'd1:    alt_src = OSC;
      default: alt_src = '0;   // bypass and reserved code count as 0 Hz
    endcase

    root_hz = periph_sel ? alt_hz : pre_hz;
    per_src = per_sel ? OSC : ipg_hz;

    unique case (stage)
      STG_TAP: begin dividend = tap_scaled; divisor = FREQ_W'(frac_pick);       end
      STG_ALT: begin dividend = alt_src;    divisor = FREQ_W'(alt_div) + ONE;  end
      STG_AHB: begin dividend = root_hz;    divisor = FREQ_W'(ahb_div) + ONE;  end
      STG_IPG: begin dividend = ahb_hz;     divisor = FREQ_W'(ipg_div) + ONE;  end
      default: begin dividend = per_src;    divisor = FREQ_W'(per_div) + ONE;  end
    endcase
  end

endmodule

// File: rtl/clkfreq_seq.sv
// Request sequencer: answers constant codes at once (R2), otherwise walks
// the division stages in a fixed order (R9).
module clkfreq_seq
  import clkfreq_pkg::*;
#(
  parameter int unsigned FREQ_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [REQ_W-1:0]  req_id,
  input  logic              div_done,
  input  logic [FREQ_W-1:0] div_quo,
  output stage_e            stage,
  output logic              div_start,
  output logic              busy,
  output logic [FREQ_W-1:0] tap_hz,
  output logic [FREQ_W-1:0] alt_hz,
  output logic [FREQ_W-1:0] ahb_hz,
  output logic [FREQ_W-1:0] ipg_hz,
  output logic              rsp_valid,
  output logic [FREQ_W-1:0] rsp_hz
);

  localparam logic [FREQ_W-1:0] OSC  = FREQ_W'(OSC_HZ);
  localparam logic [FREQ_W-1:0] OSC8 = FREQ_W'(OSC_HZ / OSC_DIV_CONST);

  phase_e            phase_q, phase_d;
  stage_e            stage_q, stage_d;
  logic              want_per_q, want_per_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [FREQ_W-1:0] rsp_hz_q, rsp_hz_d;
  logic [FREQ_W-1:0] tap_q, alt_q, ahb_q, ipg_q;
  logic              tap_en, alt_en, ahb_en, ipg_en;
  logic              last_stage;

  always_comb begin
    phase_d     = phase_q;
    stage_d     = stage_q;
    want_per_d  = want_per_q;
    rsp_valid_d = 1'b0;
    rsp_hz_d    = rsp_hz_q;
    div_start   = 1'b0;
    tap_en      = 1'b0;
    alt_en      = 1'b0;
    ahb_en      = 1'b0;
    ipg_en      = 1'b0;
    last_stage  = (stage_q == STG_PER) || (stage_q == STG_IPG && !want_per_q);

    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          unique case (req_id)
            REQ_IPG, REQ_PER: begin
              phase_d    = PH_ISSUE;
              stage_d    = STG_TAP;
              want_per_d = (req_id == REQ_PER);
            end
            REQ_OSC:      begin rsp_valid_d = 1'b1; rsp_hz_d = OSC;  end
            REQ_OSC_DIV8: begin rsp_valid_d = 1'b1; rsp_hz_d = OSC8; end
            default:      begin rsp_valid_d = 1'b1; rsp_hz_d = '0;   end
          endcase
        end
      end
      PH_ISSUE: begin
        div_start = 1'b1;
        phase_d   = PH_WAIT;
      end
      default: begin
        if (div_done) begin
          unique case (stage_q)
            STG_TAP: tap_en = 1'b1;
            STG_ALT: alt_en = 1'b1;
            STG_AHB: ahb_en = 1'b1;
            STG_IPG: ipg_en = 1'b1;
            default: ;
          endcase
          if (last_stage) begin
            phase_d     = PH_IDLE;
            rsp_valid_d = 1'b1;
            rsp_hz_d    = div_quo;
          end else begin
            phase_d = PH_ISSUE;
            unique case (stage_q)
              STG_TAP: stage_d = STG_ALT;
              STG_ALT: stage_d = STG_AHB;
              STG_AHB: stage_d = STG_IPG;
              default: stage_d = STG_PER;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      stage_q     <= STG_TAP;
      want_per_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hz_q    <= '0;
    end else begin
      phase_q     <= phase_d;
      stage_q     <= stage_d;
      want_per_q  <= want_per_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hz_q    <= rsp_hz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
      alt_q <= '0;
      ahb_q <= '0;
      ipg_q <= '0;
    end else begin
      if (tap_en) tap_q <= div_quo;
      if (alt_en) alt_q <= div_quo;
      if (ahb_en) ahb_q <= div_quo;
      if (ipg_en) ipg_q <= div_quo;
    end
  end

  assign stage     = stage_q;
  assign busy      = (phase_q != PH_IDLE);
  assign tap_hz    = tap_q;
  assign alt_hz    = alt_q;
  assign ahb_hz    = ahb_q;
  assign ipg_hz    = ipg_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_hz    = rsp_hz_q;

endmodule

// File: rtl/clkfreq_calc.sv
module clkfreq_calc
  import clkfreq_pkg::*;
#(
  parameter int unsigned FREQ_W    = 64,
  parameter int unsigned FRAC_W    = 6,
  parameter int unsigned ALT_DIV_W = 3,
  parameter int unsigned AHB_DIV_W = 3,
  parameter int unsigned IPG_DIV_W = 2,
  parameter int unsigned PER_DIV_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_id,
  input  logic                 sys_pll_x22,
  input  logic [FRAC_W-1:0]    pfd0_frac,
  input  logic [FRAC_W-1:0]    pfd2_frac,
  input  logic [1:0]           pre_sel,
  input  logic [1:0]           alt_sel,
  input  logic [ALT_DIV_W-1:0] alt_div,
  input  logic                 periph_sel,
  input  logic [AHB_DIV_W-1:0] ahb_div,
  input  logic [IPG_DIV_W-1:0] ipg_div,
  input  logic                 per_sel,
  input  logic [PER_DIV_W-1:0] per_div,
  output logic                 busy,
  output logic                 rsp_valid,
  output logic [FREQ_W-1:0]    rsp_hz
);

  logic accept;

  // captured fields, loaded only on acceptance (R12)
  logic                 x22_q;
  logic [FRAC_W-1:0]    f0_q, f2_q;
  logic [1:0]           pre_q, alt_sel_q;
  logic [ALT_DIV_W-1:0] alt_div_q;
  logic                 root_sel_q;
  logic [AHB_DIV_W-1:0] ahb_div_q;
  logic [IPG_DIV_W-1:0] ipg_div_q;
  logic                 per_sel_q;
  logic [PER_DIV_W-1:0] per_div_q;

  stage_e            stage;
  logic              div_start, div_done;
  logic [FREQ_W-1:0] div_quo, div_a, div_b;
  logic [FREQ_W-1:0] tap_hz, alt_hz, ahb_hz, ipg_hz;

  assign accept = req_valid && !busy;   // R11: ignored while busy

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x22_q      <= 1'b0;
      f0_q       <= '0;
      f2_q       <= '0;
      pre_q      <= '0;
      alt_sel_q  <= '0;
      alt_div_q  <= '0;
      root_sel_q <= 1'b0;
      ahb_div_q  <= '0;
      ipg_div_q  <= '0;
      per_sel_q  <= 1'b0;
      per_div_q  <= '0;
    end else if (accept) begin
      x22_q      <= sys_pll_x22;
      f0_q       <= pfd0_frac;
      f2_q       <= pfd2_frac;
      pre_q      <= pre_sel;
      alt_sel_q  <= alt_sel;
      alt_div_q  <= alt_div;
      root_sel_q <= periph_sel;
      ahb_div_q  <= ahb_div;
      ipg_div_q  <= ipg_div;
      per_sel_q  <= per_sel;
      per_div_q  <= per_div;
    end
  end

  clkfreq_seq #(.FREQ_W(FREQ_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_id    (req_id),
    .div_done  (div_done),
    .div_quo   (div_quo),
    .stage     (stage),
    .div_start (div_start),
    .busy      (busy),
    .tap_hz    (tap_hz),
    .alt_hz    (alt_hz),
    .ahb_hz    (ahb_hz),
    .ipg_hz    (ipg_hz),
    .rsp_valid (rsp_valid),
    .rsp_hz    (rsp_hz)
  );

  clkfreq_operands #(
    .FREQ_W(FREQ_W), .FRAC_W(FRAC_W), .ALT_DIV_W(ALT_DIV_W),
    .AHB_DIV_W(AHB_DIV_W), .IPG_DIV_W(IPG_DIV_W), .PER_DIV_W(PER_DIV_W)
  ) i_ops (
    .stage       (stage),
    .sys_pll_x22 (x22_q),
    .pfd0_frac   (f0_q),
    .pfd2_frac   (f2_q),
    .pre_sel     (pre_q),
    .alt_sel     (alt_sel_q),
    .alt_div     (alt_div_q),
    .periph_sel  (root_sel_q),
    .ahb_div     (ahb_div_q),
    .ipg_div     (ipg_div_q),
    .per_sel     (per_sel_q),
    .per_div     (per_div_q),
    .tap_hz      (tap_hz),
    .alt_hz      (alt_hz),
    .ahb_hz      (ahb_hz),
    .ipg_hz      (ipg_hz),
    .dividend    (div_a),
    .divisor     (div_b)
  );

  clkfreq_divider #(.W(FREQ_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_a),
    .divisor  (div_b),
    .done     (div_done),
    .quotient (div_quo)
  );

endmodule

// File: rtl/clkfreq_calc_chk.sv
module clkfreq_calc_chk #(
  parameter int unsigned FREQ_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_id,
  input logic              busy,
  input logic              rsp_valid,
  input logic [FREQ_W-1:0] rsp_hz
);

  localparam int unsigned STEP    = FREQ_W + 2;
  localparam int unsigned LAT_IPG = 4 * STEP + 1;
  localparam int unsigned LAT_PER = 5 * STEP + 1;

  logic        acc;
  logic        acc_div;
  logic [15:0] lat_q;
  logic        div_q, per_q;

  assign acc     = req_valid && !busy;
  assign acc_div = acc && (req_id == 3'd1 || req_id == 3'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      div_q <= 1'b0;
      per_q <= 1'b0;
    end else if (acc) begin
      lat_q <= 16'd1;
      div_q <= acc_div;
      per_q <= (req_id == 3'd2);
    end else if (busy) begin
      lat_q <= lat_q + 16'd1;
    end
  end

  p_osc_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_id == 3'd3) |=> (rsp_valid && rsp_hz == FREQ_W'(24_000_000)));

  p_osc8_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_id == 3'd4) |=> (rsp_valid && rsp_hz == FREQ_W'(3_000_000)));

  p_unsupported_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_id == 3'd0 || req_id >= 3'd5)) |=> (rsp_valid && rsp_hz == '0));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && div_q) |-> (lat_q == (per_q ? 16'(LAT_PER) : 16'(LAT_IPG))));

  p_busy_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_div |=> busy);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_hold_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && !$past(acc)) |-> $stable(rsp_hz));

  p_idle_at_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

endmodule

bind clkfreq_calc clkfreq_calc_chk #(.FREQ_W(FREQ_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_id    (req_id),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_hz    (rsp_hz)
);

// File: tb/test_clkfreq_calc.sv
module test_clkfreq_calc;

  localparam int unsigned FREQ_W = 64;
  localparam int unsigned STEP   = FREQ_W + 2;
  localparam longint unsigned OSC = 64'd24_000_000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_id;
  logic        x22;
  logic [5:0]  f0, f2;
  logic [1:0]  psel, asel;
  logic [2:0]  adiv;
  logic        rsel;
  logic [2:0]  hdiv;
  logic [1:0]  idiv;
  logic        qsel;
  logic [5:0]  qdiv;
  logic        busy;
  logic        rsp_valid;
  logic [63:0] rsp_hz;

  int n_cmp;
  int n_bad;

  clkfreq_calc i_clkfreq_calc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .sys_pll_x22(x22), .pfd0_frac(f0), .pfd2_frac(f2), .pre_sel(psel),
    .alt_sel(asel), .alt_div(adiv), .periph_sel(rsel), .ahb_div(hdiv),
    .ipg_div(idiv), .per_sel(qsel), .per_div(qdiv),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hz(rsp_hz)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] tap(input logic [5:0] fr);
    logic [63:0] pll;
    pll = OSC * (x22 ? 64'd22 : 64'd20);
    return (fr == 6'd0) ? 64'd0 : (pll * 64'd18) / 64'(fr);
  endfunction

  function automatic logic [63:0] model(input logic [2:0] id);
    logic [63:0] pll, pre, asrc, alt, root, ahb, ipg, per;
    pll = OSC * (x22 ? 64'd22 : 64'd20);
    case (psel)
      2'd0: pre = pll;
      2'd1: pre = tap(f2);
      2'd2: pre = tap(f0);
      default: pre = tap(f2) / 64'd2;
    endcase
    case (asel)
      2'd0: asrc = OSC * 64'd20;
      2'd1: asrc = OSC;
      default: asrc = 64'd0;
    endcase
    alt  = asrc / (64'(adiv) + 64'd1);
    root = rsel ? alt : pre;
    ahb  = root / (64'(hdiv) + 64'd1);
    ipg  = ahb / (64'(idiv) + 64'd1);
    per  = (qsel ? OSC : ipg) / (64'(qdiv) + 64'd1);
    case (id)
      3'd1: return ipg;
      3'd2: return per;
      3'd3: return OSC;
      3'd4: return OSC / 64'd8;
      default: return 64'd0;
    endcase
  endfunction

  task automatic scramble();
    x22 = 1'($urandom); f0 = 6'($urandom); f2 = 6'($urandom);
    psel = 2'($urandom); asel = 2'($urandom); adiv = 3'($urandom);
    rsel = 1'($urandom); hdiv = 3'($urandom); idiv = 2'($urandom);
    qsel = 1'($urandom); qdiv = 6'($urandom);
  endtask

  task automatic run_req(input logic [2:0] id, input bit meddle, input string tag);
    logic [63:0] exp_hz;
    int exp_lat;
    int lat;
    int extra;
    exp_hz  = model(id);
    exp_lat = (id == 3'd1) ? 4 * STEP + 1 : (id == 3'd2) ? 5 * STEP + 1 : 1;
    @(negedge clk);
    req_valid = 1'b1;
    req_id    = id;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    check("R10 busy after accept", 64'(busy), 64'(exp_lat > 1));
    while (!rsp_valid && lat < 2000) begin
      if (meddle && lat == 3) begin
        scramble();
        req_valid = 1'b1;
        req_id    = 3'($urandom);
      end
      if (meddle && lat == 4) req_valid = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(tag, rsp_hz, exp_hz);
    check("R9 latency", 64'(lat), 64'(exp_lat));
    check("R10 idle at answer", 64'(busy), 64'd0);
    if (meddle) check("R12 fields sampled at accept", rsp_hz, exp_hz);
    @(negedge clk);
    check("R10 pulse width", 64'(rsp_valid), 64'd0);
    check("R10 value held", rsp_hz, exp_hz);
    if (meddle) begin
      extra = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (rsp_valid) extra++;
      end
      check("R11 no answer for request while busy", 64'(extra), 64'd0);
    end
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    void'($urandom(32'h0C10_CF2E));
    rst_n = 1'b0; req_valid = 1'b0; req_id = 3'd0;
    x22 = 1'b0; f0 = 6'd24; f2 = 6'd16; psel = 2'd0; asel = 2'd0; adiv = 3'd0;
    rsel = 1'b0; hdiv = 3'd0; idiv = 3'd0; qsel = 1'b0; qdiv = 6'd0;
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 rsp_hz", rsp_hz, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 constant and unsupported codes
    run_req(3'd3, 1'b0, "R2 osc");
    run_req(3'd4, 1'b0, "R2 osc/8");
    run_req(3'd0, 1'b0, "R2 code 0");
    run_req(3'd5, 1'b0, "R2 code 5");
    run_req(3'd7, 1'b0, "R2 code 7");

    // R3 pre-mux, both multipliers
    for (int s = 0; s < 4; s++) begin
      psel = 2'(s); x22 = 1'b1; f0 = 6'd13; f2 = 6'd27;
      run_req(3'd1, 1'b0, "R3 pre select x22");
      x22 = 1'b0;
      run_req(3'd1, 1'b0, "R3 pre select x20");
    end
    // R4 zero fraction
    psel = 2'd1; f2 = 6'd0; rsel = 1'b0;
    run_req(3'd1, 1'b0, "R4 zero fraction");
    psel = 2'd2; f0 = 6'd0;
    run_req(3'd2, 1'b0, "R4 zero fraction per");
    // R5 alternate sources
    rsel = 1'b1; adiv = 3'd6;
    for (int s = 0; s < 4; s++) begin
      asel = 2'(s);
      run_req(3'd1, 1'b0, "R5 alternate source");
    end
    // R6 / R8 truncation through the chain
    rsel = 1'b0; psel = 2'd3; x22 = 1'b1; f2 = 6'd7; hdiv = 3'd6; idiv = 2'd2;
    run_req(3'd1, 1'b0, "R8 truncation per stage");
    run_req(3'd1, 1'b0, "R6 ipg chain");
    // R7 per-clock, both sources, widest divider
    qsel = 1'b1; qdiv = 6'd63;
    run_req(3'd2, 1'b0, "R7 per from osc");
    qsel = 1'b0; qdiv = 6'd5;
    run_req(3'd2, 1'b0, "R7 per from ipg");
    // R11 / R12 interference
    run_req(3'd1, 1'b1, "R12 ipg with meddling");
    run_req(3'd2, 1'b1, "R12 per with meddling");

    // random mix
    for (int n = 0; n < 180; n++) begin
      logic [2:0] id;
      logic [3:0] pick;
      scramble();
      pick = 4'($urandom);
      id = (pick < 4'd5) ? 3'd1 : (pick < 4'd10) ? 3'd2 : 3'($urandom);
      if (id == 3'd1)
        run_req(id, ($urandom % 4) == 0, "R6 random ipg");
      else if (id == 3'd2)
        run_req(id, ($urandom % 4) == 0, "R7 random per");
      else
        run_req(id, 1'b0, "R2 random code");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule